// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block sits inside a PCIe root port and collects message-signalled interrupts that arrive as inbound memory writes. Software programs a 64-bit capture address into two registers. An inbound write whose address matches that value is taken as an interrupt message. The low bits of its data select one vector among `NUM_BANKS * 32`, and the matching pending bit is set.

Vectors are arranged in banks of 32. Each bank has three registers: enable, mask and pending. An enable bit decides whether a message for that vector is captured. A mask bit only stops a captured vector from raising the interrupt line. Pending bits are cleared by writing ones to them, and software acknowledges each vector on its own. The output `irq_o` is a registered level that is high while any pending bit is both enabled and unmasked.

Software reaches the registers through a simple single-cycle bus. Writes commit on the clock edge, and read data is returned combinationally from the address.

Top module: `msi_capture_ctrl`

## Requirements
- R1: The capture address low word is read and written at byte offset 0x820, and the high word at 0x824. Both reset to 0.
- R2: Bank b (0..NUM_BANKS-1) places enable at 0x828+12*b, mask at 0x82C+12*b and pending at 0x830+12*b. Any other offset reads as 0, and writes to it change nothing.
- R3: An inbound write with `mw_addr_i` equal to {high word, low word} and data value v below NUM_BANKS*32 sets pending bit v%32 of bank v/32, provided that enable bit is 1. The bit is readable on the cycle after the write.
- R4: An inbound write is ignored when its address differs from the capture address in any bit, when its data is NUM_BANKS*32 or more, or when the selected enable bit is 0.
- R5: Writing the pending register clears exactly the bits written as 1 and leaves the others unchanged. Software can never set a pending bit.
- R6: When a captured message and a software clear hit the same pending bit in the same cycle, the bit stays set.
- R7: `irq_o` equals, one cycle late, the OR over all banks of pending AND enable AND NOT mask.
- R8: Mask bits do not stop capture. A masked vector still sets its pending bit, and removing the mask raises `irq_o`.
- R9: Enable and mask registers take the full written word. A read-modify-write of one bit leaves the other bits of the bank unchanged.
- R10: After reset every register reads 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mw_valid_i | input | 1 | Inbound memory write present |
| mw_addr_i | input | 64 | Inbound write address |
| mw_data_i | input | 32 | Inbound write data (vector number) |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register access is a write |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check the following. The interrupt line tracks the enabled, unmasked pending set one cycle late. A pending bit never appears without a matching inbound write one cycle earlier. At most one pending bit appears per cycle, and only where enable was already set. A pending bit never drops without a register write. The exact vector-to-bit mapping is shown only by the bench scenarios, and so are the rejection of near-miss addresses and out-of-range data, the collision between a message and a clear, and the register layout.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned VEC_PER_BANK = 32;
  localparam int unsigned BANK_STRIDE  = 12;
  localparam logic [11:0] TGT_LO_OFS   = 12'h820;
  localparam logic [11:0] TGT_HI_OFS   = 12'h824;
  localparam logic [11:0] BANK0_OFS    = 12'h828;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_TGT_LO,
    RK_TGT_HI,
    RK_EN,
    RK_MASK,
    RK_PEND
  } reg_kind_e;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [11:0]       addr_i,
  output reg_kind_e         kind_o,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    kind_o = RK_NONE;
    bank_o = '0;
    if (addr_i == TGT_LO_OFS) kind_o = RK_TGT_LO;
    else if (addr_i == TGT_HI_OFS) kind_o = RK_TGT_HI;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == BANK0_OFS + 12'(b * BANK_STRIDE)) begin
        kind_o = RK_EN;
        bank_o = BANK_W'(b);
      end else if (addr_i == BANK0_OFS + 12'(b * BANK_STRIDE + 4)) begin
        kind_o = RK_MASK;
        bank_o = BANK_W'(b);
      end else if (addr_i == BANK0_OFS + 12'(b * BANK_STRIDE + 8)) begin
        kind_o = RK_PEND;
        bank_o = BANK_W'(b);
      end
    end
  end
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         en_we_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q, mask_q, pend_q, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (en_we_i)   en_q   <= wdata_i;
      if (mask_we_i) mask_q <= wdata_i;
      // set wins over a same-cycle clear
      pend_q <= (pend_q & ~clr_bits) | (set_i & en_q);
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/msi_irq_reduce.sv
module msi_irq_reduce #(
  parameter int unsigned N = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_i & en_i & ~mask_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned NUM_VEC = NUM_BANKS * VEC_PER_BANK,
  localparam int unsigned BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned VEC_W   = BANK_W + 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mw_valid_i,
  input  logic [63:0] mw_addr_i,
  input  logic [31:0] mw_data_i,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [11:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  reg_kind_e         kind;
  logic [BANK_W-1:0] bank_sel;
  logic [63:0]       tgt_q;
  logic              wr, hit;
  logic [VEC_W-1:0]  vec;
  logic [31:0]       en_w   [NUM_BANKS];
  logic [31:0]       mask_w [NUM_BANKS];
  logic [31:0]       pend_w [NUM_BANKS];
  logic [NUM_VEC-1:0] en_all, mask_all, pend_all;

  msi_reg_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i (reg_addr_i),
    .kind_o (kind),
    .bank_o (bank_sel)
  );

  assign wr  = reg_req_i && reg_we_i;
  assign hit = mw_valid_i && (mw_addr_i == tgt_q) && (mw_data_i < 32'(NUM_VEC));
  assign vec = mw_data_i[VEC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (wr) begin
      if (kind == RK_TGT_LO) tgt_q[31:0]  <= reg_wdata_i;
      if (kind == RK_TGT_HI) tgt_q[63:32] <= reg_wdata_i;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic        sel;
    logic [31:0] set_v;
    assign sel   = (bank_sel == BANK_W'(b));
    assign set_v = (hit && vec[VEC_W-1:5] == BANK_W'(b)) ? (32'd1 << vec[4:0]) : 32'd0;

    msi_bank #(.W(VEC_PER_BANK)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_v),
      .en_we_i   (wr && sel && kind == RK_EN),
      .mask_we_i (wr && sel && kind == RK_MASK),
      .clr_we_i  (wr && sel && kind == RK_PEND),
      .wdata_i   (reg_wdata_i),
      .en_o      (en_w[b]),
      .mask_o    (mask_w[b]),
      .pend_o    (pend_w[b])
    );

    assign en_all[b*VEC_PER_BANK +: VEC_PER_BANK]   = en_w[b];
    assign mask_all[b*VEC_PER_BANK +: VEC_PER_BANK] = mask_w[b];
    assign pend_all[b*VEC_PER_BANK +: VEC_PER_BANK] = pend_w[b];
  end

  always_comb begin
    unique case (kind)
      RK_TGT_LO: reg_rdata_o = tgt_q[31:0];
      RK_TGT_HI: reg_rdata_o = tgt_q[63:32];
      RK_EN:     reg_rdata_o = en_w[bank_sel];
      RK_MASK:   reg_rdata_o = mask_w[bank_sel];
      RK_PEND:   reg_rdata_o = pend_w[bank_sel];
      default:   reg_rdata_o = '0;
    endcase
  end

  msi_irq_reduce #(.N(NUM_VEC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_all),
    .en_i   (en_all),
    .mask_i (mask_all),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker #(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned NUM_VEC = NUM_BANKS * 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mw_valid_i,
  input logic [63:0]        mw_addr_i,
  input logic [31:0]        mw_data_i,
  input logic               reg_req_i,
  input logic               reg_we_i,
  input logic               irq_o,
  input logic [63:0]        tgt_i,
  input logic [NUM_VEC-1:0] pend_i,
  input logic [NUM_VEC-1:0] en_i,
  input logic [NUM_VEC-1:0] mask_i
);
  logic hit_c, live_c;
  assign hit_c  = mw_valid_i && (mw_addr_i == tgt_i) && (mw_data_i < 32'(NUM_VEC));
  assign live_c = |(pend_i & en_i & ~mask_i);

  p_irq_tracks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(live_c));

  p_set_needs_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_i & ~$past(pend_i))) |-> $past(hit_c));

  p_set_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i & ~$past(pend_i) & ~$past(en_i)) == '0);

  p_one_set_per_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_i & ~$past(pend_i)) <= 1);

  p_clear_needs_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_i) & ~pend_i)) |-> $past(reg_req_i && reg_we_i));
endmodule

bind msi_capture_ctrl msi_cap_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mw_valid_i (mw_valid_i),
  .mw_addr_i  (mw_addr_i),
  .mw_data_i  (mw_data_i),
  .reg_req_i  (reg_req_i),
  .reg_we_i   (reg_we_i),
  .irq_o      (irq_o),
  .tgt_i      (tgt_q),
  .pend_i     (pend_all),
  .en_i       (en_all),
  .mask_i     (mask_all)
);

// File: tb/sim_msi_capture_ctrl.sv
module sim_msi_capture_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mw_valid_i = 1'b0;
  logic [63:0] mw_addr_i = '0;
  logic [31:0] mw_data_i = '0;
  logic        reg_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] TGT = 64'h0000_0012_3456_7000;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic [11:0] rd_addr;
    logic [31:0] exp;
  } vec_t;

  // pending offsets: bank b at 0x830 + 12*b
  localparam vec_t TBL [8] = '{
    '{TGT,                    32'd5,   12'h830, 32'h0000_0020}, // R3 bank0
    '{TGT,                    32'd37,  12'h83C, 32'h0000_0020}, // R3 bank1
    '{TGT,                    32'd255, 12'h884, 32'h8000_0000}, // R3 top vector
    '{TGT,                    32'd224, 12'h884, 32'h0000_0001}, // R3 bank7 bit0
    '{TGT,                    32'd256, 12'h830, 32'h0000_0000}, // R4 out of range
    '{64'h0000_0013_3456_7000, 32'd3,  12'h830, 32'h0000_0000}, // R4 high word miss
    '{64'h0000_0012_3456_7004, 32'd3,  12'h830, 32'h0000_0000}, // R4 low word miss
    '{TGT,                    32'd100, 12'h854, 32'h0000_0010}  // R3 bank3
  };

  msi_capture_ctrl u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    #1 d = reg_rdata_o;
    reg_req_i = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk_i);
    mw_valid_i = 1'b1; mw_addr_i = a; mw_data_i = d;
    @(negedge clk_i);
    mw_valid_i = 1'b0;
  endtask

  task automatic clear_all();
    for (int b = 0; b < 8; b++) reg_wr(12'h830 + 12'(b * 12), 32'hFFFF_FFFF);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    reg_rd(12'h820, rd); chk("R10 tgt lo", rd, 0);
    reg_rd(12'h828, rd); chk("R10 enable", rd, 0);
    reg_rd(12'h830, rd); chk("R10 pending", rd, 0);
    chk("R10 irq", {31'd0, irq_o}, 0);

    // R1 capture address
    reg_wr(12'h820, TGT[31:0]);
    reg_wr(12'h824, TGT[63:32]);
    reg_rd(12'h820, rd); chk("R1 lo", rd, TGT[31:0]);
    reg_rd(12'h824, rd); chk("R1 hi", rd, TGT[63:32]);

    // R2 unmapped offsets
    reg_wr(12'h888, 32'h1234_5678);
    reg_rd(12'h888, rd); chk("R2 beyond last bank", rd, 0);
    reg_rd(12'h82A, rd); chk("R2 unaligned", rd, 0);

    for (int b = 0; b < 8; b++) reg_wr(12'h828 + 12'(b * 12), 32'hFFFF_FFFF);

    for (int i = 0; i < 8; i++) begin
      clear_all();
      msi(TBL[i].addr, TBL[i].data);
      reg_rd(TBL[i].rd_addr, rd);
      chk($sformatf("R3/R4 table entry %0d", i), rd, TBL[i].exp);
    end
    clear_all();

    // R9 enable write and single-bit read-modify-write
    reg_wr(12'h840, 32'h0000_00F0);
    reg_rd(12'h840, rd); chk("R9 enable word", rd, 32'h0000_00F0);
    reg_wr(12'h840, rd | 32'h1);
    reg_rd(12'h840, rd); chk("R9 rmw one bit", rd, 32'h0000_00F1);

    // R4 disabled vector 72 (bank2 bit8)
    msi(TGT, 32'd72);
    reg_rd(12'h848, rd); chk("R4 disabled vector", rd, 0);

    // R8 masked vector 68 (bank2 bit4) still captured
    reg_wr(12'h844, 32'h0000_0010);
    msi(TGT, 32'd68);
    reg_rd(12'h848, rd); chk("R8 masked capture", rd, 32'h0000_0010);
    @(negedge clk_i);
    chk("R8 masked irq low", {31'd0, irq_o}, 0);
    reg_wr(12'h844, 32'h0);
    chk("R7 irq one cycle later", {31'd0, irq_o}, 0);
    @(negedge clk_i);
    chk("R7 irq high", {31'd0, irq_o}, 1);

    // R5 write-one-to-clear
    msi(TGT, 32'd69);
    reg_wr(12'h848, 32'h0000_0010);
    reg_rd(12'h848, rd); chk("R5 clear one bit", rd, 32'h0000_0020);
    reg_wr(12'h848, 32'h0);
    reg_rd(12'h848, rd); chk("R5 zero write", rd, 32'h0000_0020);

    // R6 same-cycle message and clear
    @(negedge clk_i);
    mw_valid_i = 1'b1; mw_addr_i = TGT; mw_data_i = 32'd69;
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 12'h848; reg_wdata_i = 32'h20;
    @(negedge clk_i);
    mw_valid_i = 1'b0; reg_req_i = 1'b0; reg_we_i = 1'b0;
    reg_rd(12'h848, rd); chk("R6 set wins", rd, 32'h0000_0020);

    // R7 irq falls after last clear
    reg_wr(12'h848, 32'h20);
    @(negedge clk_i);
    chk("R7 irq falls", {31'd0, irq_o}, 0);
    reg_rd(12'h848, rd); chk("R5 cleared", rd, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule